// File: doc/BRIEF.md
# Binary to Four-Digit BCD Converter

This block turns an unsigned 13-bit binary number (0 through 8191) into four packed decimal digits: thousands, hundreds, tens and units. It does no shifting or iterating. The input value drives the address of two lookup tables at the same time. Each table returns one byte. One table holds the two low-order digits and the other holds the two high-order digits.

The contents of both tables are computed while the design elaborates, by a function that extracts the decimal digits of each address. Nothing is loaded from a file. Because the output is 16 bits wide, the storage cost is two tables of 8 bits by 2^13 entries. The result passes through one register stage. A caller presents a value with a valid strobe and receives the packed digits with a matching valid flag on the next clock.

Top module: `bin2bcd4_lut`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `out_valid` to 0 and `out_bcd` to 16'h0000.
- R2: Outside reset, `out_valid` after a rising edge equals the value `in_valid` had at that edge. The result is therefore due exactly one cycle after its input was sampled.
- R3: After an edge at which `in_valid` was high, `out_bcd[3:0]` holds the units digit (input modulo 10).
- R4: After such an edge, `out_bcd[7:4]` holds the tens digit ((input / 10) modulo 10).
- R5: After such an edge, `out_bcd[11:8]` holds the hundreds digit ((input / 100) modulo 10).
- R6: After such an edge, `out_bcd[15:12]` holds the thousands digit (input / 1000), which never exceeds 8.
- R7: Every nibble of `out_bcd` is always a legal decimal digit in the range 0 to 9.
- R8: An edge at which `in_valid` is low, outside reset, leaves `out_bcd` unchanged.
- R9: The extremes and the decade boundaries are converted exactly. Examples are 0 to 16'h0000, 8191 to 16'h8191, 999 to 16'h0999, 1000 to 16'h1000, 9 and 10, and 99 and 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for `in_bin` |
| in_bin | input | 13 | Unsigned binary value to convert |
| out_valid | output | 1 | Result valid, one cycle after the accepted input |
| out_bcd | output | 16 | Packed digits: [15:12] thousands, [11:8] hundreds, [7:4] tens, [3:0] units |

## Verification
Every result is due one clock after the edge that sampled the inputs, because the tables are combinational and there is exactly one register stage. The bench drives inputs on the falling edge. After each drive it updates its expected output for the next rising edge, computing the digits by repeated subtraction. It then compares at the next falling edge, so every comparison sits a full clock after its stimulus. Cycles with the strobe low are compared against the previous value to cover holding, and reset cycles are compared against zero.

// File: rtl/bcd4_lut_pkg.sv
package bcd4_lut_pkg;

  localparam int unsigned DIG_W   = 4;
  localparam int unsigned N_DIG   = 4;
  localparam int unsigned PAIR_W  = 2 * DIG_W;
  localparam int unsigned BCD_W   = N_DIG * DIG_W;

  // Decimal digit number 'pos' (0 = units) of 'value'.
  function automatic logic [DIG_W-1:0] dec_digit(input int unsigned value,
                                                 input int unsigned pos);
    int unsigned v;
    v = value;
    for (int unsigned i = 0; i < N_DIG - 1; i++) begin
      if (i < pos) v = v / 10;
    end
    return DIG_W'(v % 10);
  endfunction

  // One table entry: two adjacent digits, the higher-order digit in the upper nibble.
  function automatic logic [PAIR_W-1:0] pair_entry(input int unsigned value,
                                                   input logic upper);
    int unsigned base;
    base = upper ? 2 : 0;
    return {dec_digit(value, base + 1), dec_digit(value, base)};
  endfunction

endpackage

// File: rtl/bcd_pair_rom.sv
module bcd_pair_rom
  import bcd4_lut_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter bit          UPPER  = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PAIR_W-1:0] pair
);

  // The table content is a constant function of the address. Each
  // variant selects which digit pair it returns.
  generate
    if (UPPER) begin : g_high_pair
      always_comb pair = pair_entry(32'(addr), 1'b1);
    end else begin : g_low_pair
      always_comb pair = pair_entry(32'(addr), 1'b0);
    end
  endgenerate

endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage
  import bcd4_lut_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [PAIR_W-1:0] lo_pair,
  input  logic [PAIR_W-1:0] hi_pair,
  output logic              q_valid,
  output logic [BCD_W-1:0]  q_bcd
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_bcd   <= '0;
    end else begin
      q_valid <= capture;
      if (capture) q_bcd <= {hi_pair, lo_pair};
    end
  end

endmodule

// File: rtl/bin2bcd4_lut.sv
module bin2bcd4_lut
  import bcd4_lut_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_bin,
  output logic              out_valid,
  output logic [BCD_W-1:0]  out_bcd
);

  logic [PAIR_W-1:0] lo_pair_w;
  logic [PAIR_W-1:0] hi_pair_w;

  bcd_pair_rom #(.ADDR_W(ADDR_W), .UPPER(1'b0)) lo_rom_i (
    .addr (in_bin),
    .pair (lo_pair_w)
  );

  bcd_pair_rom #(.ADDR_W(ADDR_W), .UPPER(1'b1)) hi_rom_i (
    .addr (in_bin),
    .pair (hi_pair_w)
  );

  bcd_out_stage out_i (
    .clk     (clk),
    .rst     (rst),
    .capture (in_valid),
    .lo_pair (lo_pair_w),
    .hi_pair (hi_pair_w),
    .q_valid (out_valid),
    .q_bcd   (out_bcd)
  );

  // Named digit views used by the checks below.
  logic [DIG_W-1:0] units_q, tens_q, hund_q, thou_q;
  assign units_q = out_bcd[3:0];
  assign tens_q  = out_bcd[7:4];
  assign hund_q  = out_bcd[11:8];
  assign thou_q  = out_bcd[15:12];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_bcd == '0));

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3 R4 R5 R6
  value_match_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (32'(thou_q) * 1000 + 32'(hund_q) * 100 + 32'(tens_q) * 10
                  + 32'(units_q)) == 32'($past(in_bin)));

  // R6
  thou_cap_chk: assert property (@(posedge clk) disable iff (rst)
    thou_q <= 4'd8);

  // R7
  nibble_legal_chk: assert property (@(posedge clk) disable iff (rst)
    units_q <= 4'd9 && tens_q <= 4'd9 && hund_q <= 4'd9 && thou_q <= 4'd9);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_bcd));

endmodule

// File: tb/bin2bcd4_lut_tb_top.sv
`timescale 1ns/1ps
module bin2bcd4_lut_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [12:0] in_bin = '0;
  logic        out_valid;
  logic [15:0] out_bcd;

  int vectors = 0;
  int errors  = 0;

  bit          have_exp = 1'b0;
  bit          exp_v;
  logic [15:0] exp_b;
  bit          last_rst;
  bit          last_v;
  string       last_tag;

  always #2.5 clk = ~clk;

  bin2bcd4_lut dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bin(in_bin),
    .out_valid(out_valid), .out_bcd(out_bcd)
  );

  // Digits by repeated subtraction.
  function automatic logic [15:0] ref_bcd(input int x);
    int th, hu, te;
    th = 0; hu = 0; te = 0;
    while (x >= 1000) begin x -= 1000; th++; end
    while (x >= 100)  begin x -= 100;  hu++; end
    while (x >= 10)   begin x -= 10;   te++; end
    return {4'(th), 4'(hu), 4'(te), 4'(x)};
  endfunction

  task automatic cmp_field(input string req, input string name,
                           input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s %s actual=%0h expected=%0h", req, last_tag, name, act, exp);
    end
  endtask

  task automatic check_now();
    string r;
    if (!have_exp) return;
    vectors++;
    if (out_valid !== exp_v) begin
      errors++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", last_rst ? "R1" : "R2",
               out_valid, exp_v);
    end
    if (last_rst) begin
      vectors++;
      if (out_bcd !== 16'h0000) begin
        errors++;
        $display("FAIL R1 out_bcd actual=%h expected=0000", out_bcd);
      end
    end else if (!last_v) begin
      vectors++;
      if (out_bcd !== exp_b) begin
        errors++;
        $display("FAIL R8 hold actual=%h expected=%h", out_bcd, exp_b);
      end
    end else begin
      cmp_field("R3", "units", out_bcd[3:0],   exp_b[3:0]);
      cmp_field("R4", "tens",  out_bcd[7:4],   exp_b[7:4]);
      cmp_field("R5", "hund",  out_bcd[11:8],  exp_b[11:8]);
      cmp_field("R6", "thou",  out_bcd[15:12], exp_b[15:12]);
    end
    // R7: legal digits regardless of context
    for (int k = 0; k < 4; k++) begin
      vectors++;
      if (out_bcd[k*4 +: 4] > 4'd9) begin
        errors++;
        $display("FAIL R7 nibble%0d actual=%0d expected<=9", k, out_bcd[k*4 +: 4]);
      end
    end
    r = "";
  endtask

  task automatic step(input bit r, input bit v, input int b, input string tag);
    @(negedge clk);
    check_now();
    rst = r; in_valid = v; in_bin = 13'(b);
    last_rst = r; last_v = v; last_tag = tag;
    if (r) begin exp_v = 1'b0; exp_b = 16'h0000; end
    else begin
      exp_v = v;
      if (v) exp_b = ref_bcd(b);
    end
    have_exp = 1'b1;
  endtask

  initial begin
    int bnd[10] = '{0, 9, 10, 99, 100, 999, 1000, 8191, 8190, 5000};
    step(1, 1, 4321, "reset");
    step(1, 0, 0, "reset");
    // R9 boundary values
    foreach (bnd[i]) step(0, 1, bnd[i], "R9");
    step(0, 0, 1234, "idle");
    step(0, 0, 77, "idle");
    // full sweep, every code
    for (int n = 0; n < 8192; n++) step(0, 1, n, "sweep");
    // random values with gaps in the strobe
    for (int n = 0; n < 3000; n++)
      step(0, ($urandom % 3) != 0, int'($urandom % 8192), "random");
    // reset in mid-stream, then resume
    step(0, 1, 8191, "R9");
    step(1, 1, 6000, "reset");
    step(0, 0, 0, "idle");
    step(0, 1, 1000, "R9");
    step(0, 0, 0, "idle");
    @(negedge clk);
    check_now();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule